// File: doc/BRIEF.md
# Reconfiguration Bitstream Sink Controller

This block runs one partial-reconfiguration transfer at a time. A start request opens an operation. The block raises a freeze output for its whole length, so surrounding logic can isolate the region being rewritten. Configuration words then arrive over a valid/ready stream in which the block is the sink. A 3-bit status output reports progress and the result.

A small built-in checker takes the place of a real configuration engine:

- The first word must carry a fixed header value.
- A CRC-32 is accumulated over every word except the final one.
- The final word carries the expected CRC.
- The number of words per operation is a parameter.

After each accepted word the block withholds ready for a number of cycles set by a clock/data ratio parameter. After the final word it runs a short trailer countdown and then drops freeze together with the final status. An error aborts the transfer at once, and its status is held until the next start.

Top module: `cfg_bitstream_sink`

## Requirements
- R1: While reset is high, and in the first cycle after it, status is 3'b000, freeze is 0 and ready is 0.
- R2: If start is sampled high while freeze is low, then in the next cycle freeze is 1, ready is 1 and status is 3'b011 (busy, no error). Any earlier result is cleared. If start is sampled high while freeze is high, no new operation begins.
- R3: A word is taken only on a clock edge at which valid and ready are both high. Ready is 0 whenever freeze is 0, so words offered before a start are not counted.
- R4: After each accepted word that is not the last, ready is 0 for exactly RATIO-1 cycles and then 1 again. With RATIO=1, ready stays high.
- R5: If the first accepted word differs from the HEADER parameter, then in the next cycle status is 3'b100 (incompatible bitstream), and freeze and ready are 0.
- R6: After the WORDS-th word is accepted, ready is 0 from the next cycle on, and valid words offered afterwards are ignored. Freeze stays 1 until the trailer ends.
- R7: Freeze falls TRAIL_CYC cycles after the edge that accepted the last word. In the same cycle status becomes 3'b101 (success) if the last word equals the CRC over words 0..WORDS-2, and 3'b010 (CRC error) otherwise. The CRC uses polynomial 0x04C11DB7 and an all-ones initial value. Each 32-bit word is shifted in MSB first, with no reflection and no final inversion.
- R8: If start is high on the edge that accepts the last word, then in the next cycle status is 3'b001 (reconfiguration error), and freeze and ready are 0.
- R9: While freeze is 0 and start stays low, status does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Operation start request |
| word_i | input | DATA_W | Configuration word |
| word_valid_i | input | 1 | Word on word_i is valid |
| word_ready_o | output | 1 | Sink can take a word this cycle |
| freeze_o | output | 1 | High while an operation runs |
| status_o | output | 3 | Progress and result code |

## Verification
On every cycle, the assertions check these relationships between signals:

- Ready never appears without freeze.
- Busy follows a start taken while idle.
- A bad header aborts on the next cycle.
- Ready drops after the last word and during the pacing gap.
- The trailer counter steps down by one each cycle.
- Status stays put while idle.

Only the bench scenarios can show the end-to-end results. These are the exact cycle on which freeze falls, success versus CRC error across every single-bit corruption of every word, the incompatible code for every corrupted header bit, the reconfiguration error when start overlaps the last word, and the fact that dummy words in the trailer are ignored.

// File: rtl/cfg_sink_pkg.sv
package cfg_sink_pkg;

  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'b000,
    ST_RECFG_ERR = 3'b001,
    ST_CRC_ERR   = 3'b010,
    ST_BUSY      = 3'b011,
    ST_INCOMPAT  = 3'b100,
    ST_OK        = 3'b101
  } sink_status_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_TRAIL = 2'd2
  } sink_phase_e;

endpackage

// File: rtl/cfg_crc_acc.sv
module cfg_crc_acc
  import cfg_sink_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              step_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);

  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] chain [0:DATA_W];

  assign chain[0] = crc_q;

  // one shift stage per input bit, MSB of the word first
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    logic fb;
    assign fb = chain[i][CRC_W-1] ^ data_i[DATA_W-1-i];
    assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) crc_q <= CRC_SEED;
    else if (step_i)    crc_q <= chain[DATA_W];
  end

  assign crc_o = crc_q;

  // R7: every operation starts its CRC from the seed
  p_crc_seed_r7: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> crc_o == CRC_SEED);

  // R7: the CRC holds when no word is folded in
  p_crc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !step_i) |=> $stable(crc_o));

endmodule

// File: rtl/cfg_ready_pacer.sv
module cfg_ready_pacer #(
  parameter int RATIO = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic take_i,
  input  logic kill_i,
  output logic ready_o
);

  localparam int WAIT_W = $clog2(RATIO + 1);
  localparam int HOLD   = RATIO - 1;

  logic              ready_q;
  logic [WAIT_W-1:0] wait_q;

  always_ff @(posedge clk) begin
    if (rst || kill_i) begin
      ready_q <= 1'b0;
      wait_q  <= '0;
    end else if (arm_i) begin
      ready_q <= 1'b1;
      wait_q  <= '0;
    end else if (take_i) begin
      ready_q <= (HOLD == 0);
      wait_q  <= WAIT_W'(HOLD);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
      if (wait_q == WAIT_W'(1)) ready_q <= 1'b1;
    end
  end

  assign ready_o = ready_q;

  if (RATIO > 1) begin : g_paced
    // R4: a processing gap follows every taken word
    p_gap_after_take_r4: assert property (@(posedge clk) disable iff (rst)
      take_i |=> !ready_o);
  end else begin : g_unpaced
    // R4: with a unit ratio a taken word keeps ready high
    p_no_gap_r4: assert property (@(posedge clk) disable iff (rst)
      (take_i && !kill_i) |=> ready_o);
  end

endmodule

// File: rtl/cfg_trail_timer.sv
module cfg_trail_timer #(
  parameter int TRAIL_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic expire_o
);

  localparam int CNT_W = $clog2(TRAIL_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= CNT_W'(TRAIL_CYC);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R7: the trailer counts down one step per cycle
  p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);

endmodule

// File: rtl/cfg_bitstream_sink.sv
module cfg_bitstream_sink
  import cfg_sink_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          WORDS     = 8,
  parameter int          RATIO     = 2,
  parameter int          TRAIL_CYC = 4,
  parameter logic [31:0] HEADER    = 32'h5EED_C0DE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              freeze_o,
  output logic [2:0]        status_o
);

  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  sink_phase_e      phase_q;
  sink_status_e     status_q;
  logic             freeze_q;
  logic             crc_bad_q;
  logic [IDX_W-1:0] idx_q;
  logic [CRC_W-1:0] crc_now;
  logic             ready;
  logic             expire;

  logic accept, is_last, hdr_bad, go;

  assign accept  = word_valid_i && ready;
  assign is_last = (idx_q == IDX_W'(WORDS - 1));
  assign hdr_bad = (idx_q == '0) && (word_i != DATA_W'(HEADER));
  assign go      = (phase_q == PH_IDLE) && start_i;

  cfg_crc_acc #(.DATA_W(DATA_W)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .clear_i (go),
    .step_i  (accept && !is_last && !hdr_bad),
    .data_i  (word_i),
    .crc_o   (crc_now)
  );

  cfg_ready_pacer #(.RATIO(RATIO)) u_pace (
    .clk     (clk),
    .rst     (rst),
    .arm_i   (go),
    .take_i  (accept && !is_last && !hdr_bad),
    .kill_i  (accept && (is_last || hdr_bad)),
    .ready_o (ready)
  );

  cfg_trail_timer #(.TRAIL_CYC(TRAIL_CYC)) u_trail (
    .clk      (clk),
    .rst      (rst),
    .load_i   (accept && is_last && !hdr_bad && !start_i),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      status_q  <= ST_IDLE;
      freeze_q  <= 1'b0;
      crc_bad_q <= 1'b0;
      idx_q     <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start_i) begin
            phase_q   <= PH_RUN;
            status_q  <= ST_BUSY;
            freeze_q  <= 1'b1;
            crc_bad_q <= 1'b0;
            idx_q     <= '0;
          end
        end
        PH_RUN: begin
          if (accept) begin
            if (hdr_bad) begin
              phase_q  <= PH_IDLE;
              status_q <= ST_INCOMPAT;
              freeze_q <= 1'b0;
            end else if (is_last) begin
              if (start_i) begin
                phase_q  <= PH_IDLE;
                status_q <= ST_RECFG_ERR;
                freeze_q <= 1'b0;
              end else begin
                phase_q   <= PH_TRAIL;
                crc_bad_q <= (word_i != DATA_W'(crc_now));
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        PH_TRAIL: begin
          if (expire) begin
            phase_q  <= PH_IDLE;
            freeze_q <= 1'b0;
            status_q <= crc_bad_q ? ST_CRC_ERR : ST_OK;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign word_ready_o = ready;
  assign freeze_o     = freeze_q;
  assign status_o     = status_q;

  // R3: the sink never offers ready outside an operation
  p_ready_needs_freeze_r3: assert property (@(posedge clk) disable iff (rst)
    word_ready_o |-> freeze_o);

  // R2: a start taken while idle opens a busy operation
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !freeze_o) |=> (freeze_o && word_ready_o && status_o == ST_BUSY));

  // R5: a wrong header aborts on the next cycle
  p_header_abort_r5: assert property (@(posedge clk) disable iff (rst)
    (accept && hdr_bad) |=> (status_o == ST_INCOMPAT && !freeze_o && !word_ready_o));

  // R6: ready stays down once the final word is in
  p_last_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (accept && is_last) |=> !word_ready_o);

  // R7: freeze only falls together with a final code
  p_freeze_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze_o) |-> (status_o != ST_BUSY && status_o != ST_IDLE));

  // R9: results are held while idle
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!freeze_o && !start_i) |=> $stable(status_o));

endmodule

// File: tb/cfg_bitstream_sink_test.sv
`timescale 1ns/1ps
module cfg_bitstream_sink_test;

  localparam int          DW     = 32;
  localparam int          NW     = 4;
  localparam int          RT     = 3;
  localparam int          TR     = 3;
  localparam logic [31:0] HDR    = 32'h5EED_C0DE;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [DW-1:0] dat = '0;
  logic          vld = 1'b0;
  logic          rdy;
  logic          frz;
  logic [2:0]    st;

  int checks = 0;
  int fails  = 0;
  logic [31:0] w [NW];

  always #2 clk = ~clk;

  cfg_bitstream_sink #(
    .DATA_W(DW), .WORDS(NW), .RATIO(RT), .TRAIL_CYC(TR), .HEADER(HDR)
  ) uut (
    .clk(clk), .rst(rst), .start_i(start), .word_i(dat),
    .word_valid_i(vld), .word_ready_o(rdy), .freeze_o(frz), .status_o(st)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 31; b >= 0; b--) begin
        logic top;
        top = c[31] ^ w[k][b];
        c = c << 1;
        if (top) c = c ^ 32'h04C1_1DB7;
      end
    return c;
  endfunction

  task automatic build(input int seed);
    w[0] = HDR;
    for (int k = 1; k < NW - 1; k++) w[k] = 32'h9E37_79B9 * (k + seed) + 32'h1234;
    w[NW-1] = ref_crc(NW - 1);
  endtask

  task automatic push(input logic [31:0] v);
    @(negedge clk);
    vld = 1'b1;
    dat = v;
    while (!rdy) @(negedge clk);
  endtask

  // one full operation; exp is the expected final status
  task automatic run_op(input int gap, input bit hold_start, input bit mid_start,
                        input logic [2:0] exp);
    bit hdr_bad;
    hdr_bad = (w[0] != HDR);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = hold_start;
    chk("R2 freeze up", frz, 1);
    chk("R2 ready up", rdy, 1);
    chk("R2 busy", st, 3'b011);
    for (int i = 0; i < NW; i++) begin
      if (mid_start && i == 2) begin
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R2 restart ignored", st, 3'b011);
      end
      for (int g = 0; g < gap; g++) @(negedge clk);
      push(w[i]);
      @(negedge clk); vld = 1'b0;
      if (i == 0 && hdr_bad) begin
        chk("R5 incompatible", st, 3'b100);
        chk("R5 freeze down", frz, 0);
        chk("R5 ready down", rdy, 0);
        return;
      end
      if (i < NW - 1) begin
        chk("R4 gap 1", rdy, 0);
        @(negedge clk); chk("R4 gap 2", rdy, 0);
        @(negedge clk); chk("R4 ready back", rdy, 1);
      end
    end
    if (hold_start) begin
      start = 1'b0;
      chk("R8 reconfig error", st, 3'b001);
      chk("R8 freeze down", frz, 0);
      chk("R8 ready down", rdy, 0);
      return;
    end
    chk("R6 ready down after last", rdy, 0);
    chk("R6 freeze held", frz, 1);
    vld = 1'b1; dat = 32'hDEAD_BEEF;
    @(negedge clk);
    chk("R6 dummy ignored", rdy, 0);
    @(negedge clk);
    chk("R7 freeze before end", frz, 1);
    chk("R7 still busy", st, 3'b011);
    @(negedge clk);
    vld = 1'b0;
    chk("R7 freeze fell", frz, 0);
    chk("R7 final status", st, exp);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status in reset", st, 3'b000);
    chk("R1 freeze in reset", frz, 0);
    chk("R1 ready in reset", rdy, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status after reset", st, 3'b000);

    // R3: valid before any start is not taken
    vld = 1'b1; dat = 32'h0BAD_0BAD;
    repeat (4) begin
      @(negedge clk);
      chk("R3 no ready while idle", rdy, 0);
    end
    vld = 1'b0;

    // plain operation, then with gaps between words
    build(0);
    run_op(0, 0, 0, 3'b101);
    build(7);
    run_op(2, 0, 0, 3'b101);

    // R9: result held while idle
    repeat (5) begin
      @(negedge clk);
      chk("R9 status held", st, 3'b101);
    end

    // R2: start during a run does not restart it
    build(3);
    run_op(0, 0, 1, 3'b101);

    // R7: every single-bit corruption of every non-header word
    for (int k = 1; k < NW; k++)
      for (int b = 0; b < 32; b++) begin
        build(k + b);
        w[k][b] = ~w[k][b];
        run_op(0, 0, 0, 3'b010);
      end

    // R5: every single-bit corruption of the header
    for (int b = 0; b < 32; b++) begin
      build(b);
      w[0][b] = ~w[0][b];
      run_op(0, 0, 0, 3'b100);
      @(negedge clk); @(negedge clk);
      chk("R9 error held", st, 3'b100);
    end

    // R8: start overlapping the last word
    build(11);
    run_op(0, 1, 0, 3'b001);
    repeat (3) begin
      @(negedge clk);
      chk("R9 reconfig error held", st, 3'b001);
    end

    // recovery after an error
    build(12);
    run_op(1, 0, 0, 3'b101);

    finish_up();
  end

endmodule